// File: doc/BRIEF.md
# Two-Wire Serial Byte-Memory Slave Engine

This block is the bus-facing half of a two-wire serial memory with 8192 bytes. A fast system clock oversamples the serial clock and data lines. The block recognises start and stop conditions. It accepts its own device-select byte, takes a two-byte word address, and pulls the data line low through an open-drain enable whenever it acknowledges a byte or sends a zero bit.

Data bytes from the master are not stored here. Each one is handed to a separate page-write sequencer as a one-cycle strobe that carries the byte and its target address. An end pulse tells the sequencer when the transaction is over. Reads go through a simple address/data port to the array. An internal counter always holds the address one past the last byte accessed, so the block supports current-address reads, random reads that use an address-only write first, and sequential reads that run on without limit.

Top module: `eeprom_bus_slave`

## Requirements
- R1: The select byte arrives MSB first as prefix 1010, then three bits that must equal `strap_i[2:0]` (bit 3 against `strap_i[2]`, down to bit 1 against `strap_i[0]`), then a direction bit in which 1 means read and 0 means write. When the select byte matches and `busy_i` is low, the slave pulls SDA low during the ninth clock.
- R2: If the prefix or the strap bits do not match, or if `busy_i` is high, the slave leaves SDA released during the ninth clock and ignores the bus until the next start.
- R3: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. A start at any point, even in the middle of a byte, drops the current transfer and makes the slave wait for a fresh select byte. The address counter keeps its value.
- R4: A write transaction carries two address bytes, high byte first. The three top bits of the high byte are ignored, and the slave acknowledges each address byte.
- R5: Each data byte in a write is acknowledged and produces one `wr_stb` pulse carrying `wr_data` and `wr_addr`. After each byte, the low five address bits advance by one and wrap inside their 32-byte page, while the upper bits stay fixed.
- R6: `wr_end` pulses once on the stop or repeated start that closes a write with at least one data byte. A write that carries only the address produces no pulse.
- R7: A read with no address phase returns the byte at the counter (last accessed address plus one). The counter wraps from 8191 to 0.
- R8: An address-only write, then a repeated start, then a read select returns data starting at the loaded address.
- R9: A read keeps sending consecutive bytes while the master acknowledges. After a master no-acknowledge, the slave releases SDA and stops driving.
- R10: The slave starts driving SDA low only while SCL is low.
- R11: After reset, SDA is released, no strobe or end pulse is active, and the address counter is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level (wired-AND bus) |
| sda_oe | output | 1 | 1 pulls the data line low |
| strap_i | input | 3 | Device-select strap bits |
| busy_i | input | 1 | Sequencer busy; suppresses the select acknowledge |
| mem_addr | output | 13 | Array read address (the address counter) |
| mem_rdata | input | 8 | Array read data at `mem_addr` |
| wr_stb | output | 1 | One-cycle pulse per received data byte |
| wr_addr | output | 13 | Target address of the strobed byte |
| wr_data | output | 8 | Strobed data byte |
| wr_end | output | 1 | One-cycle pulse closing a write with data |

## Verification
Four rules are checked on every cycle:
- the slave starts driving only while the synchronized SCL is low;
- the idle state never drives;
- a start always releases the line and returns the slave to select reception;
- a write strobe never coincides with an end pulse or a high SCL.

Some behaviour only the directed scenarios can show: select matching against the straps and the busy input, the counter carrying over between transactions, page wrap on writes, array wrap on sequential reads, and the abort of a half-received byte. Each scenario drives the bus the way a master would and compares the bytes returned and the strobes produced against values computed in the bench.

// File: rtl/tw_pkg.sv
package tw_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_DEV,
    S_AHI,
    S_ALO,
    S_WDAT,
    S_RDAT
  } tw_state_t;

  localparam logic [3:0] SEL_PREFIX = 4'b1010;
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
  parameter int LINES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] din,
  output logic [LINES-1:0] q,
  output logic [LINES-1:0] q_prev
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    logic              last;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain <= '1;
        last  <= 1'b1;
      end else begin
        chain <= {chain[STAGES-2:0], din[g]};
        last  <= chain[STAGES-1];
      end
    end
    assign q[g]      = chain[STAGES-1];
    assign q_prev[g] = last;
  end
endmodule

// File: rtl/tw_cond.sv
module tw_cond (
  input  logic scl_s,
  input  logic scl_p,
  input  logic sda_s,
  input  logic sda_p,
  output logic start_det,
  output logic stop_det,
  output logic scl_rise,
  output logic scl_fall
);
  always_comb begin
    start_det = scl_s & scl_p & sda_p & ~sda_s;
    stop_det  = scl_s & scl_p & ~sda_p & sda_s;
    scl_rise  = scl_s & ~scl_p;
    scl_fall  = ~scl_s & scl_p;
  end
endmodule

// File: rtl/tw_addr_ctr.sv
module tw_addr_ctr #(
  parameter int ADDR_W = 13,
  parameter int PAGE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_hi,
  input  logic              ld_lo,
  input  logic              inc_seq,
  input  logic              inc_page,
  input  logic [ADDR_W-9:0] hi_in,
  input  logic [7:0]        lo_in,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] addr_n;
  logic [PAGE_W-1:0] pg_low;

  always_comb begin
    addr_n = addr;
    pg_low = addr[PAGE_W-1:0] + {{(PAGE_W-1){1'b0}}, 1'b1};
    if (ld_hi)         addr_n = {hi_in, addr[7:0]};
    else if (ld_lo)    addr_n = {addr[ADDR_W-1:8], lo_in};
    else if (inc_page) addr_n = {addr[ADDR_W-1:PAGE_W], pg_low};
    else if (inc_seq)  addr_n = addr + {{(ADDR_W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr <= '0;
    else        addr <= addr_n;
  end

  a_r5_page_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_page && !ld_hi && !ld_lo) |=> addr[ADDR_W-1:PAGE_W] == $past(addr[ADDR_W-1:PAGE_W]));
  a_r7_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_seq && !inc_page && !ld_hi && !ld_lo && (&addr)) |=> addr == '0);
endmodule

// File: rtl/eeprom_bus_slave.sv
module eeprom_bus_slave #(
  parameter int ADDR_W     = 13,
  parameter int PAGE_BYTES = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [2:0]        strap_i,
  input  logic              busy_i,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rdata,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              wr_end
);
  import tw_pkg::*;

  localparam int PAGE_W = $clog2(PAGE_BYTES);

  logic [1:0] lines_q, lines_p;
  logic scl_s, sda_s, scl_p, sda_p;
  logic start_det, stop_det, scl_rise, scl_fall;

  tw_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din({scl_i, sda_i}), .q(lines_q), .q_prev(lines_p)
  );
  assign scl_s = lines_q[1];
  assign sda_s = lines_q[0];
  assign scl_p = lines_p[1];
  assign sda_p = lines_p[0];

  tw_cond u_cond (
    .scl_s(scl_s), .scl_p(scl_p), .sda_s(sda_s), .sda_p(sda_p),
    .start_det(start_det), .stop_det(stop_det), .scl_rise(scl_rise), .scl_fall(scl_fall)
  );

  tw_state_t   st, st_n;
  logic [3:0]  cnt, cnt_n;
  logic        ackp, ackp_n;
  logic [7:0]  sh, sh_n;
  logic        oe_n, mack, mack_n, wany, wany_n;
  logic        stb_n, end_n;
  logic [7:0]  wd_n;
  logic [ADDR_W-1:0] wa_n;
  logic        ld_hi, ld_lo, inc_seq, inc_page;
  logic        sel_ok;

  tw_addr_ctr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .ld_hi(ld_hi), .ld_lo(ld_lo),
    .inc_seq(inc_seq), .inc_page(inc_page),
    .hi_in(sh[ADDR_W-9:0]), .lo_in(sh), .addr(mem_addr)
  );

  assign sel_ok = (sh[7:4] == SEL_PREFIX) && (sh[3:1] == strap_i) && !busy_i;

  always_comb begin
    st_n = st; cnt_n = cnt; ackp_n = ackp; sh_n = sh; oe_n = sda_oe;
    mack_n = mack; wany_n = wany; stb_n = 1'b0; end_n = 1'b0;
    wd_n = wr_data; wa_n = wr_addr;
    ld_hi = 1'b0; ld_lo = 1'b0; inc_seq = 1'b0; inc_page = 1'b0;
    if (start_det) begin
      st_n = S_DEV; cnt_n = '0; ackp_n = 1'b0; oe_n = 1'b0;
      end_n = wany; wany_n = 1'b0;
    end else if (stop_det) begin
      st_n = S_IDLE; ackp_n = 1'b0; oe_n = 1'b0;
      end_n = wany; wany_n = 1'b0;
    end else if (st != S_IDLE) begin
      if (scl_rise) begin
        if (!ackp) begin
          cnt_n = cnt + 4'd1;
          if (st != S_RDAT) sh_n = {sh[6:0], sda_s};
        end else if (st == S_RDAT) begin
          mack_n = ~sda_s;
        end
      end
      if (scl_fall) begin
        if (!ackp && cnt == 4'd8) begin
          ackp_n = 1'b1;
          case (st)
            S_DEV: begin
              if (sel_ok) oe_n = 1'b1;
              else begin st_n = S_IDLE; ackp_n = 1'b0; end
            end
            S_AHI: begin ld_hi = 1'b1; oe_n = 1'b1; end
            S_ALO: begin ld_lo = 1'b1; oe_n = 1'b1; end
            S_WDAT: begin
              stb_n = 1'b1; wd_n = sh; wa_n = mem_addr; inc_page = 1'b1;
              wany_n = 1'b1; oe_n = 1'b1;
            end
            default: oe_n = 1'b0;
          endcase
        end else if (!ackp && st == S_RDAT && cnt != 4'd0) begin
          sh_n = {sh[6:0], 1'b0};
          oe_n = ~sh[6];
        end else if (ackp) begin
          ackp_n = 1'b0; cnt_n = '0; oe_n = 1'b0;
          case (st)
            S_DEV: begin
              if (sh[0]) begin
                st_n = S_RDAT; sh_n = mem_rdata; oe_n = ~mem_rdata[7]; inc_seq = 1'b1;
              end else begin
                st_n = S_AHI;
              end
            end
            S_AHI: st_n = S_ALO;
            S_ALO: st_n = S_WDAT;
            S_RDAT: begin
              if (mack) begin
                sh_n = mem_rdata; oe_n = ~mem_rdata[7]; inc_seq = 1'b1;
              end else begin
                st_n = S_IDLE;
              end
            end
            default: st_n = st;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; ackp <= 1'b0; sh <= '0; sda_oe <= 1'b0;
      mack <= 1'b0; wany <= 1'b0; wr_stb <= 1'b0; wr_end <= 1'b0;
      wr_data <= '0; wr_addr <= '0;
    end else begin
      st <= st_n; cnt <= cnt_n; ackp <= ackp_n; sh <= sh_n; sda_oe <= oe_n;
      mack <= mack_n; wany <= wany_n; wr_stb <= stb_n; wr_end <= end_n;
      if (stb_n) begin
        wr_data <= wd_n;
        wr_addr <= wa_n;
      end
    end
  end

  a_r10_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe && !$past(sda_oe)) |-> !$past(scl_s));
  a_r2_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !sda_oe);
  a_r3_start_resets: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (!sda_oe && st == S_DEV));
  a_r5_stb_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> !scl_s);
  a_r6_end_not_with_stb: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_stb && wr_end));
endmodule

// File: tb/tb_eeprom_bus_slave.sv
module tb_eeprom_bus_slave;
  localparam int H = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [2:0] strap = 3'b101;
  logic busy = 1'b0;
  logic sda_oe, wr_stb, wr_end;
  logic [12:0] mem_addr, wr_addr;
  logic [7:0] mem_rdata, wr_data;
  logic sda_bus;

  int checks = 0, fails = 0;
  int nstb = 0, nend = 0, r10_viol = 0;
  logic [12:0] log_a [0:7];
  logic [7:0]  log_d [0:7];
  logic done = 1'b0;
  logic prev_oe = 1'b0;

  always #5 clk = ~clk;

  assign sda_bus = sda_m & ~sda_oe;

  function automatic logic [7:0] pat(input logic [12:0] a);
    return a[7:0] ^ {a[12:8], 3'b011};
  endfunction
  assign mem_rdata = pat(mem_addr);

  eeprom_bus_slave dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
    .strap_i(strap), .busy_i(busy), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data), .wr_end(wr_end)
  );

  always @(posedge clk) begin
    if (wr_stb) begin
      if (nstb < 8) begin
        log_a[nstb] <= wr_addr;
        log_d[nstb] <= wr_data;
      end
      nstb <= nstb + 1;
    end
    if (wr_end) nend <= nend + 1;
    if (sda_oe && !prev_oe && scl_m) r10_viol <= r10_viol + 1;
    prev_oe <= sda_oe;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; w(H); scl_m = 1'b1; w(H); sda_m = 1'b0; w(H); scl_m = 1'b0; w(2);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; w(H); scl_m = 1'b1; w(H); sda_m = 1'b1; w(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; w(H); scl_m = 1'b1; w(H); scl_m = 1'b0;
    end
    sda_m = 1'b1; w(H); scl_m = 1'b1; w(H/2); ack = ~sda_bus; w(H/2); scl_m = 1'b0;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      w(H); scl_m = 1'b1; w(H/2); b[i] = sda_bus; w(H/2); scl_m = 1'b0;
    end
    sda_m = ~give_ack; w(H); scl_m = 1'b1; w(H); scl_m = 1'b0; sda_m = 1'b1;
  endtask

  task automatic t_reset();
    chk(sda_oe == 1'b0, "R11 oe", sda_oe, 0);
    chk(!wr_stb && !wr_end, "R11 pulses", {wr_stb, wr_end}, 0);
    chk(mem_addr == 13'd0, "R11 counter", mem_addr, 0);
  endtask

  task automatic t_reject();
    logic a;
    bus_start(); send_byte(8'b1010_1100, a); bus_stop();
    chk(a == 1'b0, "R2 strap mismatch", a, 0);
    bus_start(); send_byte(8'b1011_1010, a); bus_stop();
    chk(a == 1'b0, "R2 prefix mismatch", a, 0);
    busy = 1'b1;
    bus_start(); send_byte(8'b1010_1010, a); bus_stop();
    busy = 1'b0;
    chk(a == 1'b0, "R2 busy", a, 0);
    chk(nstb == 0 && nend == 0, "R2 no write activity", nstb + nend, 0);
  endtask

  task automatic t_write();
    logic a1, a2, a3, a4, a5, a6;
    bus_start();
    send_byte(8'b1010_1010, a1);
    send_byte(8'hE1, a2);
    send_byte(8'h3E, a3);
    send_byte(8'hA5, a4);
    send_byte(8'h5A, a5);
    send_byte(8'hC3, a6);
    bus_stop();
    chk(a1, "R1 select ack", a1, 1);
    chk(a2 && a3, "R4 address acks", {a2, a3}, 3);
    chk(a4 && a5 && a6, "R5 data acks", {a4, a5, a6}, 7);
    chk(nstb == 3, "R5 strobe count", nstb, 3);
    chk(log_a[0] == 13'h013E && log_d[0] == 8'hA5, "R4 first addr/data", log_a[0], 13'h013E);
    chk(log_a[1] == 13'h013F && log_d[1] == 8'h5A, "R5 second", log_a[1], 13'h013F);
    chk(log_a[2] == 13'h0120 && log_d[2] == 8'hC3, "R5 page wrap", log_a[2], 13'h0120);
    chk(nend == 1, "R6 end pulse on stop", nend, 1);
  endtask

  task automatic t_current_read();
    logic a; logic [7:0] d;
    bus_start(); send_byte(8'b1010_1011, a); recv_byte(1'b0, d); bus_stop();
    chk(a, "R7 read select ack", a, 1);
    chk(d == pat(13'h0121), "R7 current address", d, pat(13'h0121));
  endtask

  task automatic t_random_seq();
    logic a1, a2, a3, a4; logic [7:0] d0, d1, d2;
    bus_start();
    send_byte(8'b1010_1010, a1); send_byte(8'h1F, a2); send_byte(8'hFE, a3);
    bus_start();
    chk(nend == 1, "R6 no end after address-only write", nend, 1);
    send_byte(8'b1010_1011, a4);
    recv_byte(1'b1, d0); recv_byte(1'b1, d1); recv_byte(1'b0, d2);
    w(6);
    chk(sda_oe == 1'b0, "R9 released after nack", sda_oe, 0);
    bus_stop();
    chk(a1 && a2 && a3 && a4, "R8 acks", {a1, a2, a3, a4}, 15);
    chk(d0 == pat(13'h1FFE), "R8 random read", d0, pat(13'h1FFE));
    chk(d1 == pat(13'h1FFF), "R9 sequential", d1, pat(13'h1FFF));
    chk(d2 == pat(13'h0000), "R7 wrap to zero", d2, pat(13'h0000));
    chk(nend == 1, "R6 read adds no end", nend, 1);
  endtask

  task automatic t_abort();
    logic a, b; logic [7:0] d;
    bus_start(); send_byte(8'b1010_1010, a);
    for (int i = 0; i < 4; i++) begin
      sda_m = i[0]; w(H); scl_m = 1'b1; w(H); scl_m = 1'b0;
    end
    bus_start(); send_byte(8'b1010_1011, b); recv_byte(1'b0, d); bus_stop();
    chk(b, "R3 select after restart", b, 1);
    chk(d == pat(13'h0001), "R3 counter kept through abort", d, pat(13'h0001));
    chk(nstb == 3 && nend == 1, "R3 no write from aborted byte", nstb, 3);
  endtask

  initial begin
    w(5); rst_n = 1'b1; w(5);
    t_reset();
    t_reject();
    t_write();
    t_current_read();
    t_random_seq();
    t_abort();
    chk(r10_viol == 0, "R10 drive starts with scl low", r10_viol, 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule